// File: doc/BRIEF.md
# Accumulator Register-Operand ALU Executor

This block carries out the register-operand data instructions of a small 8-bit accumulator machine whose instruction words are 13 bits wide. Each cycle it takes an instruction word, the accumulator value, the value of the addressed register and the current carry flag. It returns the result byte, a write strobe for either the accumulator or the register, new Z, C and DC values with a per-flag update mask, and a request to skip the next instruction.

The supported group covers add, subtract (register minus accumulator), increment and decrement (plain and skip-on-zero), OR, AND, XOR, complement, clears, the two moves, rotates through carry, and nibble swap. One instruction bit picks the destination. The register file, program counter, stack and control registers stay outside. The surrounding core applies the write strobes and the masked flags. The datapath is combinational. A parameter adds one output register stage, with asynchronous active-low reset, and that stage is on by default.

Top module: `acc_alu_exec`

## Requirements
- R1: An instruction is recognised only when bits 12:11 are 0. Bits 10:7 form the operation code, bit 6 is the destination (0 = accumulator, 1 = register) and bits 5:0 are the register address. A recognised instruction raises exactly one of acc_we_o or reg_we_o and drives its result on res_o.
- R2: Code 0x7 (add) gives A+R. C is the carry out of bit 7 and DC is the carry out of bit 3.
- R3: Code 0x2 (subtract) gives R-A. C is 1 when R >= A, DC is 1 when R[3:0] >= A[3:0], and Z is also updated.
- R4: The following codes update only Z: 0x4 OR (A|R), 0x5 AND (A&R), 0x6 XOR (A^R), 0x9 complement (~R), 0xA increment (R+1), 0x3 decrement (R-1) and 0x8 move (R).
- R5: Encoding 0x0080 writes 0 to the accumulator. Encodings 0x00C0-0x00FF write 0 to the register. Both update only Z. Encodings 0x0081-0x00BF are unrecognised.
- R6: Code 0xC rotates R right through carry: old C goes to bit 7 and R[0] goes to C. Code 0xD rotates left: old C goes to bit 0 and R[7] goes to C. Both update only C.
- R7: Code 0xE swaps the nibbles of R. Code 0x0 with bit 6 set (0x0040-0x007F) writes A to the register. Neither changes any flag.
- R8: Code 0xB (decrement-skip) and code 0xF (increment-skip) write R-1 or R+1 to the destination. They raise skip_o exactly when that result is 0 and change no flag.
- R9: For every instruction that updates Z, Z is 1 exactly when the 8-bit result is 0.
- R10: flag_we_o is ordered {Z, C, DC}. When its bit is clear, z_o and dc_o read 0 and c_o reads c_i.
- R11: Unrecognised encodings give no write strobe, a zero flag mask, no skip and res_o = 0. This covers bit 12 set, bit 11 set, 0x0000-0x003F and 0x0081-0x00BF.
- R12: With the output stage on, outputs follow the inputs of the previous rising clock edge. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 13 | Instruction word |
| acc_i | input | 8 | Accumulator value |
| reg_i | input | 8 | Addressed register value |
| c_i | input | 1 | Current carry flag |
| res_o | output | 8 | Result byte |
| acc_we_o | output | 1 | Write result to accumulator |
| reg_we_o | output | 1 | Write result to register |
| flag_we_o | output | 3 | Flag update mask {Z, C, DC} |
| z_o | output | 1 | New zero flag |
| c_o | output | 1 | New carry flag |
| dc_o | output | 1 | New digit-carry flag |
| skip_o | output | 1 | Skip-next request |

## Verification
The bench targets subtraction where R and A are equal, where A exceeds R, and where only the low nibble borrows. A design that computed A-R, or inverted the borrow sense, would report the wrong C or DC on one of these cases. It rotates single set bits through both carry values, so a swapped rotate direction or a missing carry-in shows up as a wrong result byte. It also sends zero results from instructions that do not own Z, which catches a Z flag leaking out through an unmasked path. The 0x0080/0x0081 boundary and the skip forms at 0x01 and 0xFF catch over-broad clear decoding and skips raised on nonzero results.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    OP_NONE, OP_MOVA, OP_CLR, OP_SUB, OP_DEC, OP_OR, OP_AND, OP_XOR, OP_ADD,
    OP_MOVR, OP_COM, OP_INC, OP_DJZ, OP_RRC, OP_RLC, OP_SWAP, OP_IJZ
  } op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic dc;
  } flags_t;

  function automatic flags_t flag_mask(op_e op);
    flags_t m;
    m = '0;
    case (op)
      OP_ADD, OP_SUB: m = '{z: 1'b1, c: 1'b1, dc: 1'b1};
      OP_CLR, OP_DEC, OP_OR, OP_AND, OP_XOR, OP_MOVR, OP_COM, OP_INC:
        m.z = 1'b1;
      OP_RRC, OP_RLC: m.c = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic uses_adder(op_e op);
    return op inside {OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_DJZ, OP_IJZ};
  endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
#(
  parameter int INSTR_W = 13,
  parameter int ADDR_W  = 6
) (
  input  logic [INSTR_W-1:0] instr_i,
  output op_e                op_o,
  output logic               dst_reg_o
);
  localparam int SEL_LO = ADDR_W + 1;
  localparam int SEL_HI = ADDR_W + 4;
  localparam int TOP_LO = ADDR_W + 5;

  logic [3:0]        sel;
  logic [ADDR_W-1:0] addr;
  logic              upper_clear;

  assign sel         = instr_i[SEL_HI:SEL_LO];
  assign addr        = instr_i[ADDR_W-1:0];
  assign dst_reg_o   = instr_i[ADDR_W];
  assign upper_clear = ~|instr_i[INSTR_W-1:TOP_LO];

  always_comb begin
    op_o = OP_NONE;
    if (upper_clear) begin
      case (sel)
        4'h0: op_o = dst_reg_o ? OP_MOVA : OP_NONE;
        // accumulator clear exists only at address zero
        4'h1: op_o = (dst_reg_o || addr == '0) ? OP_CLR : OP_NONE;
        4'h2: op_o = OP_SUB;
        4'h3: op_o = OP_DEC;
        4'h4: op_o = OP_OR;
        4'h5: op_o = OP_AND;
        4'h6: op_o = OP_XOR;
        4'h7: op_o = OP_ADD;
        4'h8: op_o = OP_MOVR;
        4'h9: op_o = OP_COM;
        4'hA: op_o = OP_INC;
        4'hB: op_o = OP_DJZ;
        4'hC: op_o = OP_RRC;
        4'hD: op_o = OP_RLC;
        4'hE: op_o = OP_SWAP;
        4'hF: op_o = OP_IJZ;
        default: op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] r_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              dc_o
);
  localparam int NIB = DATA_W / 2;

  logic [DATA_W-1:0] x, y;
  logic              cin;
  logic [DATA_W:0]   sum;

  // one adder serves add, subtract (R + ~A + 1), increment and decrement
  always_comb begin
    x   = r_i;
    y   = '0;
    cin = 1'b0;
    case (op_i)
      OP_ADD:         y = a_i;
      OP_SUB:         begin y = ~a_i; cin = 1'b1; end
      OP_INC, OP_IJZ: cin = 1'b1;
      OP_DEC, OP_DJZ: y = '1;
      default:        ;
    endcase
  end

  assign sum   = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  assign res_o = sum[DATA_W-1:0];
  assign c_o   = sum[DATA_W];
  // carry into the upper nibble recovered from the sum bit
  assign dc_o  = x[NIB] ^ y[NIB] ^ sum[NIB];
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] r_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);
  localparam int NIB = DATA_W / 2;

  always_comb begin
    res_o = '0;
    c_o   = c_i;
    case (op_i)
      OP_OR:   res_o = a_i | r_i;
      OP_AND:  res_o = a_i & r_i;
      OP_XOR:  res_o = a_i ^ r_i;
      OP_COM:  res_o = ~r_i;
      OP_MOVR: res_o = r_i;
      OP_MOVA: res_o = a_i;
      OP_CLR:  res_o = '0;
      OP_RRC:  begin res_o = {c_i, r_i[DATA_W-1:1]}; c_o = r_i[0]; end
      OP_RLC:  begin res_o = {r_i[DATA_W-2:0], c_i}; c_o = r_i[DATA_W-1]; end
      OP_SWAP: res_o = {r_i[NIB-1:0], r_i[DATA_W-1:NIB]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int INSTR_W = 13,
  parameter int ADDR_W  = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  acc_i,
  input  logic [DATA_W-1:0]  reg_i,
  input  logic               c_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               acc_we_o,
  output logic               reg_we_o,
  output logic [2:0]         flag_we_o,
  output logic               z_o,
  output logic               c_o,
  output logic               dc_o,
  output logic               skip_o
);
  localparam int NIB = DATA_W / 2;

  op_e               op;
  logic              dst_reg;
  logic [DATA_W-1:0] ar_res, bo_res, res_n;
  logic              ar_c, ar_dc, bo_c;
  flags_t            mask;
  logic              hit, zero_n;
  logic              acc_we_n, reg_we_n, z_n, c_n, dc_n, skip_n;

  acc_alu_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) u_dec (
    .instr_i  (instr_i),
    .op_o     (op),
    .dst_reg_o(dst_reg)
  );

  acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i (op),
    .a_i  (acc_i),
    .r_i  (reg_i),
    .res_o(ar_res),
    .c_o  (ar_c),
    .dc_o (ar_dc)
  );

  acc_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op_i (op),
    .a_i  (acc_i),
    .r_i  (reg_i),
    .c_i  (c_i),
    .res_o(bo_res),
    .c_o  (bo_c)
  );

  always_comb begin
    mask     = flag_mask(op);
    hit      = (op != OP_NONE);
    res_n    = uses_adder(op) ? ar_res : bo_res;
    zero_n   = (res_n == '0);
    acc_we_n = hit & ~dst_reg;
    reg_we_n = hit & dst_reg;
    z_n      = mask.z & zero_n;
    c_n      = mask.c ? (uses_adder(op) ? ar_c : bo_c) : c_i;
    dc_n     = mask.dc & ar_dc;
    skip_n   = (op == OP_DJZ || op == OP_IJZ) && zero_n;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_o     <= '0;
        acc_we_o  <= 1'b0;
        reg_we_o  <= 1'b0;
        flag_we_o <= '0;
        z_o       <= 1'b0;
        c_o       <= 1'b0;
        dc_o      <= 1'b0;
        skip_o    <= 1'b0;
      end else begin
        res_o     <= res_n;
        acc_we_o  <= acc_we_n;
        reg_we_o  <= reg_we_n;
        flag_we_o <= mask;
        z_o       <= z_n;
        c_o       <= c_n;
        dc_o      <= dc_n;
        skip_o    <= skip_n;
      end
    end
  end else begin : g_comb
    always_comb begin
      res_o     = res_n;
      acc_we_o  = acc_we_n;
      reg_we_o  = reg_we_n;
      flag_we_o = mask;
      z_o       = z_n;
      c_o       = c_n;
      dc_o      = dc_n;
      skip_o    = skip_n;
    end
  end

  a_r2_add_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ADD) |-> ({ar_c, ar_res} == ({1'b0, acc_i} + {1'b0, reg_i})));

  a_r3_sub_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SUB) |-> (ar_c == (reg_i >= acc_i)));

  a_r3_sub_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SUB) |-> (ar_dc == (reg_i[NIB-1:0] >= acc_i[NIB-1:0])));

  a_r6_rrc_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RRC) |-> (bo_res[DATA_W-1] == c_i && bo_c == reg_i[0]));

  a_r1_one_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_we_o, reg_we_o}));

  a_r8_skip_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (res_o == '0 && flag_we_o == '0));

  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_we_o || reg_we_o) |-> (!skip_o && flag_we_o == '0));
endmodule

// File: tb/acc_alu_exec_test.sv
`timescale 1ns/1ps
module acc_alu_exec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] instr = '0;
  logic [7:0]  acc = '0, rg = '0;
  logic        cin = 1'b0;
  logic [7:0]  res;
  logic        awe, rwe, z, c, dc, skip;
  logic [2:0]  fwe;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  acc_alu_exec uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .acc_i(acc), .reg_i(rg),
    .c_i(cin), .res_o(res), .acc_we_o(awe), .reg_we_o(rwe), .flag_we_o(fwe),
    .z_o(z), .c_o(c), .dc_o(dc), .skip_o(skip)
  );

  function automatic logic [12:0] enc(input logic [3:0] code, input logic d,
                                      input logic [5:0] ad);
    return {2'b00, code, d, ad};
  endfunction

  // packed view: res, awe, rwe, mask{z,c,dc}, z, c, dc, skip
  function automatic logic [15:0] outs();
    return {res, awe, rwe, fwe, z, c, dc, skip};
  endfunction

  task automatic check_now(input logic [15:0] exp, input string tag);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, outs(), exp);
    end
  endtask

  task automatic run(input logic [12:0] ins, input logic [7:0] a, input logic [7:0] r,
                     input logic ci, input logic [7:0] e_res, input logic e_awe,
                     input logic e_rwe, input logic [2:0] e_mask, input logic e_z,
                     input logic e_c, input logic e_dc, input logic e_skip,
                     input string tag);
    @(negedge clk);
    instr = ins; acc = a; rg = r; cin = ci;
    @(negedge clk);
    check_now({e_res, e_awe, e_rwe, e_mask, e_z, e_c, e_dc, e_skip}, tag);
  endtask

  task automatic t_reset();
    instr = enc(4'h7, 1'b0, 6'h01); acc = 8'h11; rg = 8'h22; cin = 1'b1;
    repeat (3) @(negedge clk);
    check_now(16'h0000, "R12 reset clears outputs");
    rst_n = 1'b1;
  endtask

  task automatic t_dest();
    run(enc(4'h7, 1'b0, 6'h05), 8'h12, 8'h34, 1'b0, 8'h46, 1, 0, 3'b111, 0, 0, 0, 0, "R1 add to acc");
    run(enc(4'h7, 1'b1, 6'h05), 8'h12, 8'h34, 1'b0, 8'h46, 0, 1, 3'b111, 0, 0, 0, 0, "R1 add to reg");
  endtask

  task automatic t_add();
    run(enc(4'h7, 1'b0, 6'h10), 8'h01, 8'hFF, 1'b0, 8'h00, 1, 0, 3'b111, 1, 1, 1, 0, "R2 add wrap");
    run(enc(4'h7, 1'b1, 6'h10), 8'h08, 8'h08, 1'b1, 8'h10, 0, 1, 3'b111, 0, 0, 1, 0, "R2 add half carry");
  endtask

  task automatic t_sub();
    run(enc(4'h2, 1'b0, 6'h02), 8'h20, 8'h50, 1'b0, 8'h30, 1, 0, 3'b111, 0, 1, 1, 0, "R3 sub no borrow");
    run(enc(4'h2, 1'b0, 6'h02), 8'h50, 8'h20, 1'b1, 8'hD0, 1, 0, 3'b111, 0, 0, 1, 0, "R3 sub borrow");
    run(enc(4'h2, 1'b1, 6'h02), 8'h05, 8'h13, 1'b0, 8'h0E, 0, 1, 3'b111, 0, 1, 0, 0, "R3 sub nibble borrow");
    run(enc(4'h2, 1'b1, 6'h02), 8'h44, 8'h44, 1'b0, 8'h00, 0, 1, 3'b111, 1, 1, 1, 0, "R3 R9 sub equal");
  endtask

  task automatic t_logic();
    run(enc(4'h4, 1'b0, 6'h03), 8'h0F, 8'hF0, 1'b1, 8'hFF, 1, 0, 3'b100, 0, 1, 0, 0, "R4 R10 or");
    run(enc(4'h5, 1'b0, 6'h03), 8'h0F, 8'hF0, 1'b1, 8'h00, 1, 0, 3'b100, 1, 1, 0, 0, "R4 R9 and zero");
    run(enc(4'h6, 1'b1, 6'h03), 8'h55, 8'h55, 1'b0, 8'h00, 0, 1, 3'b100, 1, 0, 0, 0, "R4 xor zero");
    run(enc(4'h9, 1'b0, 6'h03), 8'h00, 8'hFF, 1'b0, 8'h00, 1, 0, 3'b100, 1, 0, 0, 0, "R4 complement");
    run(enc(4'hA, 1'b1, 6'h03), 8'h00, 8'hFF, 1'b0, 8'h00, 0, 1, 3'b100, 1, 0, 0, 0, "R4 inc no skip");
    run(enc(4'h3, 1'b0, 6'h03), 8'h00, 8'h01, 1'b1, 8'h00, 1, 0, 3'b100, 1, 1, 0, 0, "R4 dec");
    run(enc(4'h8, 1'b0, 6'h03), 8'h77, 8'h00, 1'b0, 8'h00, 1, 0, 3'b100, 1, 0, 0, 0, "R4 move to acc");
    run(enc(4'h8, 1'b1, 6'h03), 8'h77, 8'h80, 1'b0, 8'h80, 0, 1, 3'b100, 0, 0, 0, 0, "R4 move to reg");
  endtask

  task automatic t_clear();
    run(13'h0080, 8'h9A, 8'h9A, 1'b0, 8'h00, 1, 0, 3'b100, 1, 0, 0, 0, "R5 clear acc");
    run(13'h00C5, 8'h9A, 8'h9A, 1'b1, 8'h00, 0, 1, 3'b100, 1, 1, 0, 0, "R5 clear reg");
    run(13'h0081, 8'h9A, 8'h9A, 1'b0, 8'h00, 0, 0, 3'b000, 0, 0, 0, 0, "R5 R11 0x0081 unused");
  endtask

  task automatic t_rotate();
    run(enc(4'hC, 1'b0, 6'h07), 8'h00, 8'h01, 1'b0, 8'h00, 1, 0, 3'b010, 0, 1, 0, 0, "R6 R10 rrc out");
    run(enc(4'hC, 1'b1, 6'h07), 8'h00, 8'h80, 1'b1, 8'hC0, 0, 1, 3'b010, 0, 0, 0, 0, "R6 rrc in");
    run(enc(4'hD, 1'b0, 6'h07), 8'h00, 8'h80, 1'b0, 8'h00, 1, 0, 3'b010, 0, 1, 0, 0, "R6 rlc out");
    run(enc(4'hD, 1'b1, 6'h07), 8'h00, 8'h01, 1'b1, 8'h03, 0, 1, 3'b010, 0, 0, 0, 0, "R6 rlc in");
  endtask

  task automatic t_swap_move();
    run(enc(4'hE, 1'b0, 6'h08), 8'h00, 8'hA5, 1'b1, 8'h5A, 1, 0, 3'b000, 0, 1, 0, 0, "R7 swap");
    run(enc(4'h0, 1'b1, 6'h08), 8'h3C, 8'hFF, 1'b0, 8'h3C, 0, 1, 3'b000, 0, 0, 0, 0, "R7 move acc to reg");
    run(enc(4'h0, 1'b1, 6'h08), 8'h00, 8'hFF, 1'b0, 8'h00, 0, 1, 3'b000, 0, 0, 0, 0, "R7 move zero no Z");
  endtask

  task automatic t_skip();
    run(enc(4'hB, 1'b1, 6'h09), 8'h00, 8'h01, 1'b0, 8'h00, 0, 1, 3'b000, 0, 0, 0, 1, "R8 djz skip");
    run(enc(4'hB, 1'b0, 6'h09), 8'h00, 8'h05, 1'b0, 8'h04, 1, 0, 3'b000, 0, 0, 0, 0, "R8 djz no skip");
    run(enc(4'hF, 1'b0, 6'h09), 8'h00, 8'hFF, 1'b1, 8'h00, 1, 0, 3'b000, 0, 1, 0, 1, "R8 ijz skip");
    run(enc(4'hF, 1'b1, 6'h09), 8'h00, 8'h10, 1'b0, 8'h11, 0, 1, 3'b000, 0, 0, 0, 0, "R8 ijz no skip");
  endtask

  task automatic t_unknown();
    run(13'h1000, 8'h12, 8'h34, 1'b1, 8'h00, 0, 0, 3'b000, 0, 1, 0, 0, "R11 bit12 set");
    run(13'h09C5, 8'h12, 8'h34, 1'b0, 8'h00, 0, 0, 3'b000, 0, 0, 0, 0, "R11 bit11 set");
    run(13'h0010, 8'h12, 8'h34, 1'b0, 8'h00, 0, 0, 3'b000, 0, 0, 0, 0, "R11 low misc");
  endtask

  task automatic t_latency();
    run(enc(4'h7, 1'b0, 6'h01), 8'h12, 8'h34, 1'b0, 8'h46, 1, 0, 3'b111, 0, 0, 0, 0, "R12 setup");
    @(negedge clk);
    instr = enc(4'hE, 1'b1, 6'h01); rg = 8'hA5;
    #1;
    check_now({8'h46, 1'b1, 1'b0, 3'b111, 4'b0000}, "R12 holds before edge");
    @(negedge clk);
    check_now({8'h5A, 1'b0, 1'b1, 3'b000, 4'b0000}, "R12 updates after edge");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_dest();
    t_add();
    t_sub();
    t_logic();
    t_clear();
    t_rotate();
    t_swap_move();
    t_skip();
    t_unknown();
    t_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule